// File: doc/BRIEF.md
# Serial Core Run-State Controller

This block is the control and status register slice of a small serial-protocol core. A three-state run machine (reset, run, pause) is steered by software through a state register. Each accepted state change passes through a fixed settling window. During that window the state register's valid bit reads zero. Software polls until valid is set and the reported code equals the code it asked for. A software-reset register forces the machine back to reset from any condition.

The block also holds an operational register, an error-flag register, an error-enable register and a master-status register. The operational register shows live FIFO levels from the data path and two edge-generated service flags. The error-flag and master-status registers are sticky and are cleared by writing one. The data path reads `engine_en_o` to know when it may move data. It reads `flush_o` to empty its FIFOs when the machine re-enters reset. Software watches `err_irq_o` for enabled errors.

The bus is a single-cycle 32-bit write strobe with a word index. Read data is combinational from the index. Register indices: 0 state, 1 software reset, 2 operational, 3 error flags, 4 error enable, 5 master status. Other indices read zero.

Top module: `sercore_runctl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the state register reads 0x4 (code 00 = reset, bit 2 valid = 1). The operational, error-flag and master-status registers read 0. `engine_en_o`, `flush_o` and `err_irq_o` are 0.
- R2: A state write is accepted when valid is 1 and `wdata_i[31:2]` is zero. The state code is `wdata_i[1:0]`: 00 = reset, 01 = run, 11 = pause, and 10 = reset request. An accepted write clears valid for exactly SETTLE_CYC cycles. Valid then returns to 1 and bits [1:0] read the new code.
- R3: A state write made while valid is 0, or with any of `wdata_i[31:2]` set, is ignored. The state does not change, and a rejected write does not clear valid.
- R4: In pause, a reset request (code 00 or 10) takes effect only on the second of two consecutive accepted state writes that both request reset. The first such write leaves the register reading pause with valid 1. An accepted run or pause write in between cancels the first request.
- R5: Writing bit 0 = 1 to the software-reset register at any time clears valid. Valid returns after SETTLE_CYC cycles with code 00. A write with bit 0 = 0 has no effect.
- R6: `engine_en_o` is 1 exactly while the reported code is run. It is 0 in pause and in reset.
- R7: Every completed entry into reset raises `flush_o` for one cycle and clears both service flags. While the code is reset, operational bits [2:0] read 0. In pause they still show the live FIFO inputs.
- R8: Operational bit 8 (output service) is set when `out_nempty_i` falls from 1 to 0 outside reset. Writing 1 to bit 8 clears it. Live bits are bit 0 = output not empty, bit 1 = output full, bit 2 = input not empty.
- R9: Operational bit 9 (input service) is set when `in_nempty_i` rises outside reset. Writing 1 to bit 9 clears it. A level that is already high when reset is left does not set it.
- R10: Error-flag bits [6:2] (mask 0x7C) are set by `err_evt_i[4:0]` and stay set until a one is written to them. Writing 0x7C clears all of them. The error-enable register keeps only bits [6:2]. `err_irq_o` is the OR of the flags ANDed with the enables.
- R11: Master-status bits [25:2] are set by `mst_evt_i[23:0]`, are sticky, and clear when a one is written to them. Bits [31:26] and [1:0] read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| out_nempty_i | input | 1 | Output FIFO not empty |
| out_full_i | input | 1 | Output FIFO full |
| in_nempty_i | input | 1 | Input FIFO holds received data |
| err_evt_i | input | 5 | Error events, one per error-flag bit 2..6 |
| mst_evt_i | input | 24 | Master status events, one per bit 2..25 |
| engine_en_o | output | 1 | Data-path engine enable |
| flush_o | output | 1 | One-cycle FIFO flush on reset entry |
| err_irq_o | output | 1 | Enabled error pending |

## Verification
A wrong settle count or a lost target code shows on the state register in one of two ways. Valid either returns a cycle early or late, or it returns with the wrong code. So the bench samples valid on every cycle of the window rather than only at its end. A stuck pause arming bit shows at once: the first reset request from pause drops valid when it should not, or the second one fails to. A flag that misses its set edge, its one-to-clear or its flush appears on the very next read of the operational or error registers. A wrong `flush_o` count appears by the cycle on which reset is reported.

// File: rtl/sercore_runctl_pkg.sv
// Package: shared state codes and register indices for the run-state controller.
// Assumes a 32-bit register bus addressed by a 3-bit word index.
package sercore_runctl_pkg;

    localparam int BUS_W = 32;
    localparam int IDX_W = 3;

    typedef enum logic [1:0] {
        ST_RESET = 2'b00,
        ST_RUN   = 2'b01,
        ST_CLR   = 2'b10,
        ST_PAUSE = 2'b11
    } run_code_e;

    localparam logic [IDX_W-1:0] REG_STATE  = 3'd0;
    localparam logic [IDX_W-1:0] REG_SWRST  = 3'd1;
    localparam logic [IDX_W-1:0] REG_OPSTAT = 3'd2;
    localparam logic [IDX_W-1:0] REG_ERRFLG = 3'd3;
    localparam logic [IDX_W-1:0] REG_ERREN  = 3'd4;
    localparam logic [IDX_W-1:0] REG_MSTAT  = 3'd5;

    localparam int OP_OUT_SVC_BIT = 8;
    localparam int OP_IN_SVC_BIT  = 9;

endpackage

// File: rtl/sercore_runctl_fsm.sv
// Module: run-state machine with settle window and two-step pause-to-reset.
// Assumes SETTLE_CYC >= 1. wr_i is a state-register write strobe, and
// range_ok_i says that the upper write bits are zero.
module sercore_runctl_fsm
    import sercore_runctl_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [1:0] wcode_i,
    input  logic       range_ok_i,
    input  logic       swrst_i,
    output run_code_e  code_o,
    output logic       valid_o,
    output logic       enter_reset_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    run_code_e        cur_q, tgt_q;
    logic [CNT_W-1:0] cnt_q;
    logic             valid_q;
    logic             armed_q;
    logic             accept, reset_req, done;
    run_code_e        wcode;

    // Decode the incoming write and the end of the settle window.
    always_comb begin
        wcode     = run_code_e'(wcode_i);
        accept    = wr_i && valid_q && range_ok_i;
        reset_req = (wcode == ST_RESET) || (wcode == ST_CLR);
        done      = !valid_q && (cnt_q == CNT_ONE);
    end

    // State, target, settle counter and pause arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= ST_RESET;
            tgt_q   <= ST_RESET;
            cnt_q   <= '0;
            valid_q <= 1'b1;
            armed_q <= 1'b0;
        end else if (swrst_i) begin
            tgt_q   <= ST_RESET;
            cnt_q   <= CNT_LOAD;
            valid_q <= 1'b0;
            armed_q <= 1'b0;
        end else if (accept) begin
            if (cur_q == ST_PAUSE && reset_req && !armed_q) begin
                armed_q <= 1'b1;
            end else begin
                armed_q <= 1'b0;
                tgt_q   <= reset_req ? ST_RESET : wcode;
                cnt_q   <= CNT_LOAD;
                valid_q <= 1'b0;
            end
        end else if (done) begin
            cur_q   <= tgt_q;
            valid_q <= 1'b1;
            cnt_q   <= '0;
        end else if (!valid_q) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // Outputs to the register view and to the flag logic.
    always_comb begin
        code_o        = cur_q;
        valid_o       = valid_q;
        enter_reset_o = done && (tgt_q == ST_RESET) && !swrst_i;
    end

    // R2: the reported code only moves when valid returns.
    p_busy_code_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |=> ($stable(cur_q) || valid_q));

    // R3: a write during the window leaves the target untouched.
    p_busy_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !valid_q && !swrst_i) |=> $stable(tgt_q));

    // R4: arming happens only from a settled pause.
    p_arm_only_in_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> (cur_q == ST_PAUSE && valid_q));

    // R5: a software reset always opens a settle window.
    p_swrst_drops_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_i |=> !valid_q);

endmodule

// File: rtl/sercore_runctl_svc.sv
// Module: edge-generated service flags with write-one-to-clear.
// Index 0 is the output flag (falling edge), index 1 the input flag (rising).
// Assumes hold_i is high while the machine is in reset; flush_i wins over all.
module sercore_runctl_svc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_i,
    input  logic       flush_i,
    input  logic [1:0] lvl_i,
    input  logic [1:0] clr_i,
    output logic [1:0] svc_o
);
    localparam logic [1:0] FALL_SEL = 2'b01;

    for (genvar g = 0; g < 2; g++) begin : g_flag
        logic prev_q, flag_q, edge_hit;

        // Pick the edge direction for this flag.
        always_comb begin
            if (FALL_SEL[g]) edge_hit = prev_q && !lvl_i[g];
            else             edge_hit = !prev_q && lvl_i[g];
        end

        // Track the level and update the sticky flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                flag_q <= 1'b0;
            end else begin
                prev_q <= lvl_i[g];
                if (flush_i)                    flag_q <= 1'b0;
                else if (edge_hit && !hold_i)   flag_q <= 1'b1;
                else if (clr_i[g])              flag_q <= 1'b0;
            end
        end

        assign svc_o[g] = flag_q;

        // R7: a flush leaves the flag clear.
        p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flush_i |=> !flag_q);

        // R8 and R9: the flag never sets while held in reset.
        p_no_set_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_i && !flag_q) |=> !flag_q);
    end

endmodule

// File: rtl/sercore_runctl_w1c.sv
// Module: bank of sticky event bits, cleared by writing one.
// Assumes set_i and clr_i are already aligned to the bank's bit 0; set wins.
module sercore_runctl_w1c #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    // Keep bits until cleared; new events take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

    // R10 and R11: a one written without a new event clears the bit.
    p_w1c_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

    // R11: bits not cleared stay set.
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i)));

endmodule

// File: rtl/sercore_runctl.sv
// Module: top of the run-state controller: decodes writes and muxes reads.
// It joins the state machine, the service flags and two sticky banks.
// Assumes single-cycle writes and combinational reads on a word index.
module sercore_runctl
    import sercore_runctl_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    parameter int ERR_LSB    = 2,
    parameter int ERR_W      = 5,
    parameter int MST_LSB    = 2,
    parameter int MST_W      = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   addr_i,
    input  logic [BUS_W-1:0]   wdata_i,
    output logic [BUS_W-1:0]   rdata_o,
    input  logic               out_nempty_i,
    input  logic               out_full_i,
    input  logic               in_nempty_i,
    input  logic [ERR_W-1:0]   err_evt_i,
    input  logic [MST_W-1:0]   mst_evt_i,
    output logic               engine_en_o,
    output logic               flush_o,
    output logic               err_irq_o
);
    run_code_e        code;
    logic             valid, enter_reset, in_reset;
    logic             wr_state, wr_swrst, wr_op, wr_err, wr_en_reg, wr_mst;
    logic             range_ok;
    logic [1:0]       svc, svc_clr, live_lvl;
    logic [ERR_W-1:0] err_flags, err_clr, err_en_q;
    logic [MST_W-1:0] mst_flags, mst_clr;

    // Write decode per register.
    always_comb begin
        wr_state  = wr_en_i && (addr_i == REG_STATE);
        wr_swrst  = wr_en_i && (addr_i == REG_SWRST) && wdata_i[0];
        wr_op     = wr_en_i && (addr_i == REG_OPSTAT);
        wr_err    = wr_en_i && (addr_i == REG_ERRFLG);
        wr_en_reg = wr_en_i && (addr_i == REG_ERREN);
        wr_mst    = wr_en_i && (addr_i == REG_MSTAT);
        range_ok  = (wdata_i[BUS_W-1:2] == '0);
        svc_clr   = wr_op  ? {wdata_i[OP_IN_SVC_BIT], wdata_i[OP_OUT_SVC_BIT]} : 2'b00;
        err_clr   = wr_err ? wdata_i[ERR_LSB +: ERR_W] : '0;
        mst_clr   = wr_mst ? wdata_i[MST_LSB +: MST_W] : '0;
        live_lvl  = {in_nempty_i, out_nempty_i};
    end

    sercore_runctl_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (wr_state),
        .wcode_i       (wdata_i[1:0]),
        .range_ok_i    (range_ok),
        .swrst_i       (wr_swrst),
        .code_o        (code),
        .valid_o       (valid),
        .enter_reset_o (enter_reset)
    );

    assign in_reset = (code == ST_RESET);

    sercore_runctl_svc u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (in_reset),
        .flush_i (enter_reset),
        .lvl_i   (live_lvl),
        .clr_i   (svc_clr),
        .svc_o   (svc)
    );

    sercore_runctl_w1c #(.W(ERR_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (err_evt_i),
        .clr_i   (err_clr),
        .flags_o (err_flags)
    );

    sercore_runctl_w1c #(.W(MST_W)) u_mst (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (mst_evt_i),
        .clr_i   (mst_clr),
        .flags_o (mst_flags)
    );

    // Error-enable register: only the implemented flag positions are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_en_q <= '0;
        else if (wr_en_reg) err_en_q <= wdata_i[ERR_LSB +: ERR_W];
    end

    // Read mux; live FIFO bits are hidden while in reset.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_STATE: begin
                rdata_o[1:0] = code;
                rdata_o[2]   = valid;
            end
            REG_OPSTAT: begin
                rdata_o[0] = out_nempty_i && !in_reset;
                rdata_o[1] = out_full_i   && !in_reset;
                rdata_o[2] = in_nempty_i  && !in_reset;
                rdata_o[OP_OUT_SVC_BIT] = svc[0];
                rdata_o[OP_IN_SVC_BIT]  = svc[1];
            end
            REG_ERRFLG: rdata_o[ERR_LSB +: ERR_W] = err_flags;
            REG_ERREN:  rdata_o[ERR_LSB +: ERR_W] = err_en_q;
            REG_MSTAT:  rdata_o[MST_LSB +: MST_W] = mst_flags;
            default:    rdata_o = '0;
        endcase
    end

    // Data-path controls.
    always_comb begin
        engine_en_o = (code == ST_RUN);
        flush_o     = enter_reset;
        err_irq_o   = |(err_flags & err_en_q);
    end

    // R6: the engine stops on the cycle after a flush.
    p_no_engine_after_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !engine_en_o);

endmodule

// File: tb/sercore_runctl_bench.sv
`timescale 1ns/1ps
module sercore_runctl_bench;
    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        out_nempty = 1'b0, out_full = 1'b0, in_nempty = 1'b0;
    logic [4:0]  err_evt = '0;
    logic [23:0] mst_evt = '0;
    logic        engine_en, flush, err_irq;

    int n_chk = 0, n_fail = 0, flush_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sercore_runctl #(.SETTLE_CYC(SETTLE)) u_sercore_runctl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .out_nempty_i(out_nempty),
        .out_full_i(out_full), .in_nempty_i(in_nempty), .err_evt_i(err_evt),
        .mst_evt_i(mst_evt), .engine_en_o(engine_en), .flush_o(flush),
        .err_irq_o(err_irq)
    );

    always @(negedge clk) if (flush) flush_cnt++;

    // Table: {write code, expected code}, walked from the reset state.
    localparam logic [3:0] TBL [7] = '{
        4'b01_01, 4'b11_11, 4'b01_01, 4'b10_00, 4'b01_01, 4'b00_00, 4'b11_11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle();
        repeat (SETTLE + 1) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int fc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(3'd0, d); check("R1 state", d, 32'h4);
        rd(3'd2, d); check("R1 opstat", d, 32'h0);
        rd(3'd3, d); check("R1 errflg", d, 32'h0);
        rd(3'd5, d); check("R1 mstat", d, 32'h0);
        check("R1 outputs", {29'b0, engine_en, flush, err_irq}, 32'h0);

        // R2 / R6: table of transitions with the settle window
        for (int e = 0; e < 7; e++) begin
            bit low_ok;
            bus_write(3'd0, {30'b0, TBL[e][3:2]});
            rd(3'd0, d); low_ok = !d[2];
            for (int i = 1; i < SETTLE; i++) begin
                @(negedge clk); rd(3'd0, d);
                if (d[2]) low_ok = 0;
            end
            check("R2 valid low window", {31'b0, low_ok}, 32'h1);
            @(negedge clk); rd(3'd0, d);
            check("R2 settled code", d, {29'b0, 1'b1, TBL[e][1:0]});
            check("R6 engine", {31'b0, engine_en}, {31'b0, TBL[e][1:0] == 2'b01});
        end

        // R4: pause needs two reset requests
        fc = flush_cnt;
        bus_write(3'd0, 32'h2); rd(3'd0, d); check("R4 first request holds pause", d, 32'h7);
        bus_write(3'd0, 32'h2); rd(3'd0, d); check("R4 second request starts", d, 32'h3);
        settle(); rd(3'd0, d); check("R4 reached reset", d, 32'h4);
        check("R7 one flush", flush_cnt - fc, 1);
        bus_write(3'd0, 32'h3); settle();
        bus_write(3'd0, 32'h0); rd(3'd0, d); check("R4 arm via 00", d, 32'h7);
        bus_write(3'd0, 32'h3); settle(); rd(3'd0, d); check("R4 pause write disarms", d, 32'h7);
        bus_write(3'd0, 32'h2); rd(3'd0, d); check("R4 re-armed not done", d, 32'h7);
        bus_write(3'd0, 32'h2); settle(); rd(3'd0, d); check("R4 reset after pair", d, 32'h4);

        // R3: writes while busy or out of range are ignored
        bus_write(3'd0, 32'h1); bus_write(3'd0, 32'h3);
        settle(); rd(3'd0, d); check("R3 busy write ignored", d, 32'h5);
        bus_write(3'd0, 32'h7); rd(3'd0, d); check("R3 out-of-range ignored", d, 32'h5);

        // R5: software reset
        bus_write(3'd1, 32'h2); rd(3'd0, d); check("R5 bit0 clear no effect", d, 32'h5);
        bus_write(3'd1, 32'h1); rd(3'd0, d); check("R5 valid drops", d & 32'h4, 32'h0);
        settle(); rd(3'd0, d); check("R5 reset reached", d, 32'h4);
        bus_write(3'd0, 32'h1); bus_write(3'd1, 32'h1);
        settle(); rd(3'd0, d); check("R5 during window", d, 32'h4);
        check("R6 engine off in reset", {31'b0, engine_en}, 32'h0);

        // R7 / R8 / R9: live bits and service flags
        out_nempty = 1; out_full = 1; in_nempty = 1;
        @(negedge clk); rd(3'd2, d); check("R7 live masked in reset", d, 32'h0);
        bus_write(3'd0, 32'h1); settle();
        rd(3'd2, d); check("R9 no set from held level", d, 32'h7);
        out_nempty = 0; @(negedge clk);
        rd(3'd2, d); check("R8 out service set", d, 32'h106);
        in_nempty = 0; @(negedge clk); in_nempty = 1; @(negedge clk);
        rd(3'd2, d); check("R9 in service set", d, 32'h306);
        bus_write(3'd2, 32'h100); rd(3'd2, d); check("R8 write-one clears", d, 32'h206);
        bus_write(3'd0, 32'h3); settle();
        rd(3'd2, d); check("R7 pause keeps live", d, 32'h206);
        fc = flush_cnt;
        bus_write(3'd0, 32'h0); bus_write(3'd0, 32'h0); settle();
        rd(3'd2, d); check("R7 reset clears flags", d, 32'h0);
        check("R7 flush count", flush_cnt - fc, 1);
        bus_write(3'd2, 32'h200); rd(3'd2, d); check("R9 stays clear", d, 32'h0);

        // R10: error flags, enables and irq
        @(negedge clk); err_evt = 5'b10101; @(negedge clk); err_evt = '0;
        rd(3'd3, d); check("R10 flags set", d, 32'h54);
        check("R10 irq masked", {31'b0, err_irq}, 32'h0);
        bus_write(3'd4, 32'hFFFF_FFFF); rd(3'd4, d); check("R10 enable width", d, 32'h7C);
        check("R10 irq on", {31'b0, err_irq}, 32'h1);
        bus_write(3'd3, 32'h04); rd(3'd3, d); check("R10 partial clear", d, 32'h50);
        bus_write(3'd3, 32'h7C); rd(3'd3, d); check("R10 full clear", d, 32'h0);
        check("R10 irq off", {31'b0, err_irq}, 32'h0);

        // R11: master status
        @(negedge clk); mst_evt = '1; @(negedge clk); mst_evt = '0;
        rd(3'd5, d); check("R11 all set", d, 32'h03FF_FFFC);
        bus_write(3'd5, 32'hFFFF_0FFC); rd(3'd5, d); check("R11 partial clear", d, 32'h0000_F000);
        bus_write(3'd5, 32'h03FF_FFFC); rd(3'd5, d); check("R11 clear all", d, 32'h0);

        done = 1;
        report();
        $finish;
    end
endmodule